// File: doc/BRIEF.md
# Half-Duplex Transmit Retry Engine

This block drives frames from a byte-wide transmit FIFO onto a byte-wide line interface for an Ethernet MAC. A 32-bit control word sets three things: whether transmission is on, whether short frames are lengthened to the 64-byte minimum with zero data bytes, and how many retransmissions a frame gets after its first attempt.

In half-duplex mode a collision stops the current attempt. The engine then tells the FIFO to return its read pointer to the start of the frame. It waits a random number of slot times, chosen by truncated binary exponential backoff, and sends the frame again from its first byte. The retry limit is programmable. When a frame collides once more than that limit allows, the engine drops it, reports an excessive-collision failure and moves on to the next frame. In full-duplex mode collisions are ignored.

Turning the enable bit off lets the frame in progress finish, including any retries it still needs. The engine then starts no new frame, and queued frames stay in the FIFO until transmission is turned back on. The FIFO is show-ahead. The engine commits a frame, which releases it in the FIFO, when the frame succeeds or is dropped.

Top module: `hdx_tx_engine`

## Requirements
- R1: After reset the control word reads 0x00000008, which means padding on, transmitter off and retry limit 0. The line stays idle.
- R2: Only bits 11:4 (retry limit), bit 3 (pad) and bit 1 (enable) can be written. Every other bit reads 0, so writing all ones reads back 0x00000FFA.
- R3: No frame starts while the enable bit is 0. A queued frame waits and is sent once enable is set.
- R4: A frame goes out byte for byte in FIFO order, with line_last on its final byte. One cycle after that byte, frame_done and frame_ok pulse together.
- R5: With pad set, a frame shorter than 64 bytes is followed by 0x00 bytes up to 64 bytes in total. With pad clear, a short frame is sent unchanged. A frame of 64 bytes or more is never lengthened.
- R6: A half-duplex collision on collision number n rewinds the frame and resends it from byte 0. The gap from the collided byte's cycle to the resend's first byte, minus 2 cycles, is r·SLOT_CLKS clock cycles, where 0 ≤ r < 2^min(n,10).
- R7: Let T be the retry limit. Collision number T+1 on a frame drops the frame. One cycle later excess_col and frame_done pulse with frame_ok low. The next queued frame then follows. With T = 0 the first collision drops the frame.
- R8: With full_duplex high, the collision input has no effect: there is no rewind, no drop, and the frame completes whole.
- R9: Clearing enable during a frame lets that frame complete. The following queued frame does not start until enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| full_duplex | input | 1 | 1 = full duplex, collisions ignored |
| fifo_avail | input | 1 | At least one complete frame is queued |
| fifo_data | input | 8 | Byte at the FIFO read pointer (show-ahead) |
| fifo_last | input | 1 | fifo_data is the final byte of the frame |
| fifo_pop | output | 1 | Advance the read pointer |
| fifo_rewind | output | 1 | Return the read pointer to the frame start |
| fifo_commit | output | 1 | Release the current frame, successful or dropped |
| line_valid | output | 1 | line_data holds a frame byte |
| line_data | output | 8 | Transmitted byte |
| line_last | output | 1 | Final byte of the frame |
| collision | input | 1 | Collision seen during the current byte |
| frame_done | output | 1 | One-cycle pulse: frame finished |
| frame_ok | output | 1 | With frame_done: 1 = sent, 0 = dropped |
| excess_col | output | 1 | One-cycle pulse: frame dropped after too many collisions |

## Verification
Frames are tried in several forms. Frames of different lengths and contents are sent with no collision, which shows data ordering and the framing marker. Short and long frames are sent with padding on and off, which separates lengthening from pass-through. Frames are hit with collisions at the first byte and in the middle of the frame, with a few retries and with more than ten, and every backoff gap is checked against its exponent bound, including the clamp at 10. Finally, collision counts are set just past the retry limit, collisions are raised in full-duplex mode, and enable is cleared mid-frame. These separate a drop from a retry, an ignored collision from an honoured one, and draining from stopping at once.

// File: rtl/hdx_tx_pkg.sv
package hdx_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_PAD  = 2'd2,
    ST_WAIT = 2'd3
  } tx_state_t;

  localparam int          CTL_W     = 32;
  localparam int          THR_LSB   = 4;
  localparam int          THR_W     = 8;
  localparam int          PAD_BIT   = 3;
  localparam int          EN_BIT    = 1;
  localparam logic [31:0] CTL_RESET = 32'h0000_0008;
  localparam logic [31:0] CTL_WMASK = 32'h0000_0FFA;
  localparam int          BO_CLAMP  = 10;

  // Slot-count mask for collision number n: 2^min(n,10) - 1
  function automatic logic [9:0] bo_mask(input logic [8:0] n);
    int          e;
    logic [10:0] t;
    e = (int'(n) > BO_CLAMP) ? BO_CLAMP : int'(n);
    t = (11'd1 << e) - 11'd1;
    return t[9:0];
  endfunction

endpackage

// File: rtl/hdx_tx_csr.sv
module hdx_tx_csr
  import hdx_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] rdata,
  output logic             tx_en,
  output logic             pad_en,
  output logic [THR_W-1:0] col_thr
);

  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= CTL_RESET;
    else if (we) ctl_q <= wdata & CTL_WMASK;
  end

  assign rdata   = ctl_q;
  assign tx_en   = ctl_q[EN_BIT];
  assign pad_en  = ctl_q[PAD_BIT];
  assign col_thr = ctl_q[THR_LSB +: THR_W];

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[0] == 1'b0) && (rdata[2] == 1'b0) && (rdata[31:12] == '0)); // R2
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[11:3] == $past(wdata[11:3])) && (rdata[1] == $past(wdata[1]))); // R2

endmodule

// File: rtl/hdx_tx_lfsr.sv
module hdx_tx_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] rnd
);

  logic [W-1:0] s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    s_q <= SEED;
    else if (s_q[0]) s_q <= (s_q >> 1) ^ TAPS;
    else           s_q <= s_q >> 1;
  end

  assign rnd = s_q;

  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rnd != '0); // R6

endmodule

// File: rtl/hdx_tx_backoff.sv
module hdx_tx_backoff
  import hdx_tx_pkg::*;
#(
  parameter int SLOT_CLKS = 64,
  parameter int RND_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [8:0]       col_num,
  input  logic [RND_W-1:0] rnd,
  output logic             expired
);

  localparam int CNT_W = 11 + $clog2(SLOT_CLKS);

  logic [CNT_W-1:0] cnt_q;
  logic [9:0]       slots;

  assign slots = rnd[9:0] & bo_mask(col_num);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= CNT_W'(slots) * CNT_W'(SLOT_CLKS);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_BO_WITHIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q <= CNT_W'($past(bo_mask(col_num))) * CNT_W'(SLOT_CLKS))); // R6
  AST_BO_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6

endmodule

// File: rtl/hdx_tx_engine.sv
module hdx_tx_engine
  import hdx_tx_pkg::*;
#(
  parameter int SLOT_CLKS = 64,
  parameter int MIN_LEN   = 64,
  parameter int LEN_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        full_duplex,
  input  logic        fifo_avail,
  input  logic [7:0]  fifo_data,
  input  logic        fifo_last,
  output logic        fifo_pop,
  output logic        fifo_rewind,
  output logic        fifo_commit,
  output logic        line_valid,
  output logic [7:0]  line_data,
  output logic        line_last,
  input  logic        collision,
  output logic        frame_done,
  output logic        frame_ok,
  output logic        excess_col
);

  localparam int RND_W = 16;
  localparam logic [LEN_W-1:0] LAST_IDX = LEN_W'(MIN_LEN - 1);

  logic             tx_en, pad_en;
  logic [THR_W-1:0] col_thr;
  logic [RND_W-1:0] rnd;
  logic             bo_expired;

  tx_state_t        state_q, state_d;
  logic [LEN_W-1:0] byte_q, byte_d;
  logic [8:0]       ncol_q, ncol_d;

  // Named internal events
  logic in_frame, hd_col, ev_start, need_pad, ev_ok, ev_abort, ev_retry;

  hdx_tx_csr u_csr (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .tx_en(tx_en), .pad_en(pad_en), .col_thr(col_thr)
  );

  hdx_tx_lfsr #(.W(RND_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .rnd(rnd));

  hdx_tx_backoff #(.SLOT_CLKS(SLOT_CLKS), .RND_W(RND_W)) u_bo (
    .clk(clk), .rst_n(rst_n), .load(ev_retry), .col_num(ncol_q + 9'd1),
    .rnd(rnd), .expired(bo_expired)
  );

  assign in_frame = (state_q == ST_SEND) || (state_q == ST_PAD);
  assign hd_col   = in_frame && collision && !full_duplex;
  assign ev_start = (state_q == ST_IDLE) && tx_en && fifo_avail;
  assign need_pad = pad_en && (byte_q < LAST_IDX);
  assign ev_abort = hd_col && (ncol_q >= {1'b0, col_thr});
  assign ev_retry = hd_col && !ev_abort;

  // Line side
  assign line_valid = in_frame;
  assign line_data  = (state_q == ST_SEND) ? fifo_data : 8'h00;
  assign line_last  = ((state_q == ST_SEND) && fifo_last && !need_pad) ||
                      ((state_q == ST_PAD) && (byte_q == LAST_IDX));
  assign ev_ok      = line_last && !hd_col;

  // FIFO side
  assign fifo_pop    = (state_q == ST_SEND) && !hd_col;
  assign fifo_rewind = ev_retry;
  assign fifo_commit = ev_ok || ev_abort;

  always_comb begin
    state_d = state_q;
    byte_d  = byte_q;
    ncol_d  = ncol_q;
    unique case (state_q)
      ST_IDLE: if (ev_start) begin
        state_d = ST_SEND;
        byte_d  = '0;
        ncol_d  = '0;
      end
      ST_SEND, ST_PAD: begin
        if (ev_abort) begin
          state_d = ST_IDLE;
        end else if (ev_retry) begin
          state_d = ST_WAIT;
          byte_d  = '0;
          ncol_d  = ncol_q + 9'd1;
        end else if (ev_ok) begin
          state_d = ST_IDLE;
        end else begin
          byte_d = byte_q + 1'b1;
          if (state_q == ST_SEND && fifo_last) state_d = ST_PAD;
        end
      end
      ST_WAIT: if (bo_expired) state_d = ST_SEND;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      byte_q     <= '0;
      ncol_q     <= '0;
      frame_done <= 1'b0;
      frame_ok   <= 1'b0;
      excess_col <= 1'b0;
    end else begin
      state_q    <= state_d;
      byte_q     <= byte_d;
      ncol_q     <= ncol_d;
      frame_done <= ev_ok || ev_abort;
      frame_ok   <= ev_ok;
      excess_col <= ev_abort;
    end
  end

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> (!line_valid || $past(tx_en))); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (line_last && !collision) |=> (frame_done && frame_ok)); // R4
  AST_PAD_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (line_last && pad_en) |-> (byte_q >= LAST_IDX)); // R5
  AST_RETRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rewind |=> !line_valid); // R6
  AST_EXCESS_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    excess_col |-> (frame_done && !frame_ok)); // R7
  AST_ONE_FIFO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_rewind, fifo_commit})); // R7
  AST_FD_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |-> (!fifo_rewind && !ev_abort)); // R8

endmodule

// File: tb/hdx_tx_engine_tb.sv
`timescale 1ns/1ps
module hdx_tx_engine_tb;

  localparam int SLOT = 4;
  localparam int WATCHDOG_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        full_duplex = 1'b0;
  logic        fifo_avail;
  logic [7:0]  fifo_data;
  logic        fifo_last;
  logic        fifo_pop, fifo_rewind, fifo_commit;
  logic        line_valid, line_last;
  logic [7:0]  line_data;
  logic        collision = 1'b0;
  logic        frame_done, frame_ok, excess_col;

  always #10 clk = ~clk;

  hdx_tx_engine #(.SLOT_CLKS(SLOT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .full_duplex(full_duplex), .fifo_avail(fifo_avail), .fifo_data(fifo_data),
    .fifo_last(fifo_last), .fifo_pop(fifo_pop), .fifo_rewind(fifo_rewind),
    .fifo_commit(fifo_commit), .line_valid(line_valid), .line_data(line_data),
    .line_last(line_last), .collision(collision), .frame_done(frame_done),
    .frame_ok(frame_ok), .excess_col(excess_col)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int seed, input int i);
    return 8'(seed * 31 + i * 7 + 1);
  endfunction

  // ---------------- FIFO model ----------------
  logic [7:0] fmem [0:2047];
  int fstart [0:15];
  int flen   [0:15];
  int nfr = 0, wr_ptr = 0;
  int fidx, rd_ptr;

  always_comb begin
    fifo_avail = (fidx < nfr);
    fifo_data  = fmem[rd_ptr[10:0]];
    fifo_last  = fifo_avail && (rd_ptr == fstart[fidx[3:0]] + flen[fidx[3:0]] - 1);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fidx   <= 0;
      rd_ptr <= 0;
    end else if (fifo_commit) begin
      fidx   <= fidx + 1;
      rd_ptr <= fstart[fidx[3:0]] + flen[fidx[3:0]];
    end else if (fifo_rewind) begin
      rd_ptr <= fstart[fidx[3:0]];
    end else if (fifo_pop) begin
      rd_ptr <= rd_ptr + 1;
    end
  end

  task automatic load_frame(input int len, input int seed);
    fstart[nfr] = wr_ptr;
    flen[nfr]   = len;
    for (int i = 0; i < len; i++) fmem[wr_ptr + i] = exp_byte(seed, i);
    wr_ptr += len;
    nfr++;
  endtask

  // ---------------- Line monitor / collision injector ----------------
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] cap [0:255];
  int cap_n = 0, got_len = 0, done_cnt = 0, exc_cnt = 0, col_done = 0;
  int col_seq = 0, last_col = 0, gap = 0;
  bit got_ok = 1'b0, resume_pend = 1'b0;
  int col_req = 0;   // written by tasks only
  int col_at  = 0;   // written by tasks only

  always @(negedge clk) begin
    if (rst_n) begin
      if (collision) begin
        collision = 1'b0;
        if (!full_duplex) begin
          last_col = cyc - 1;
          cap_n = 0;
          col_seq++;
          resume_pend = 1'b1;
        end
      end
      if (frame_done) begin
        done_cnt++;
        got_ok = frame_ok;
        if (excess_col) exc_cnt++;
        if (frame_ok) got_len = cap_n;
        cap_n = 0;
        col_seq = 0;
        resume_pend = 1'b0;
      end
      if (line_valid) begin
        if (resume_pend) begin
          // R6: gap in whole slots, below 2^min(n,10) slots
          gap = cyc - last_col - 2;
          chk((gap % SLOT == 0) && (gap / SLOT < (1 << ((col_seq > 10) ? 10 : col_seq))),
              "R6 backoff gap", gap, SLOT * (1 << ((col_seq > 10) ? 10 : col_seq)));
          resume_pend = 1'b0;
        end
        if (col_done < col_req && cap_n == col_at) begin
          collision = 1'b1;
          col_done++;
        end
        if (!(collision && !full_duplex)) begin
          cap[cap_n[7:0]] = line_data;
          cap_n++;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] cfg(input int thr, input bit pad, input bit en);
    return (32'(thr) << 4) | (32'(pad) << 3) | (32'(en) << 1);
  endfunction

  task automatic wait_done(input int prev, input string tag);
    int n = 0;
    while (done_cnt == prev && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done_cnt > prev, {tag, " frame_done seen"}, done_cnt, prev + 1);
  endtask

  task automatic check_bytes(input int seed, input int dlen, input int tot, input string tag);
    int bad = 0;
    for (int i = 0; i < tot; i++) begin
      if (i < dlen) begin
        if (cap[i] !== exp_byte(seed, i)) bad++;
      end else if (cap[i] !== 8'h00) bad++;
    end
    chk(bad == 0, {tag, " byte mismatches"}, bad, 0);
  endtask

  task automatic send_one(input int len, input int seed, input int exp_len, input string tag);
    int d = done_cnt;
    load_frame(len, seed);
    wait_done(d, tag);
    chk(got_ok == 1'b1, {tag, " frame_ok"}, int'(got_ok), 1);
    chk(got_len == exp_len, {tag, " length"}, got_len, exp_len);
    check_bytes(seed, len, exp_len, tag);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(cfg_rdata == 32'h8, "R1 reset control word", int'(cfg_rdata), 8);
    chk(line_valid == 1'b0, "R1 line idle", int'(line_valid), 0);
  endtask

  task automatic t_csr;
    write_cfg(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h0000_0FFA, "R2 write mask", int'(cfg_rdata), 32'hFFA);
    write_cfg(32'h0000_0005);
    chk(cfg_rdata == 32'h0, "R2 reserved bits ignore writes", int'(cfg_rdata), 0);
  endtask

  task automatic t_hold;
    int seen = 0;
    int d = done_cnt;
    write_cfg(cfg(15, 0, 0));
    load_frame(20, 3);
    repeat (100) begin
      @(negedge clk);
      if (line_valid) seen++;
    end
    chk(seen == 0, "R3 no start while disabled", seen, 0);
    write_cfg(cfg(15, 0, 1));
    wait_done(d, "R3");
    chk(got_len == 20, "R3 held frame sent after enable", got_len, 20);
    check_bytes(3, 20, 20, "R3");
  endtask

  task automatic t_basic;
    send_one(64, 5, 64, "R4 len64");
    send_one(100, 9, 100, "R4 len100");
    send_one(1, 11, 1, "R4 len1");
  endtask

  task automatic t_pad;
    write_cfg(cfg(15, 1, 1));
    send_one(10, 13, 64, "R5 pad short");
    send_one(70, 17, 70, "R5 pad long");
    send_one(63, 19, 64, "R5 pad 63");
    write_cfg(cfg(15, 0, 1));
    send_one(10, 21, 10, "R5 no pad");
  endtask

  task automatic t_retry;
    int e = exc_cnt;
    col_at = 4;
    col_req = col_done + 3;
    send_one(30, 23, 30, "R6 three retries");
    chk(col_done == col_req, "R6 collisions consumed", col_done, col_req);
    chk(exc_cnt == e, "R6 no excess", exc_cnt - e, 0);
    col_at = 0;
    col_req = col_done + 12;
    send_one(25, 29, 25, "R6 twelve retries clamp");
  endtask

  task automatic t_excess;
    int d = done_cnt;
    int e = exc_cnt;
    write_cfg(cfg(2, 0, 1));
    col_at = 3;
    col_req = col_done + 3;
    load_frame(20, 31);
    load_frame(25, 37);
    wait_done(d, "R7");
    chk(got_ok == 1'b0, "R7 dropped frame not ok", int'(got_ok), 0);
    chk(exc_cnt == e + 1, "R7 excess pulse", exc_cnt - e, 1);
    wait_done(d + 1, "R7 next");
    chk(got_ok == 1'b1 && got_len == 25, "R7 next frame sent", got_len, 25);
    check_bytes(37, 25, 25, "R7 next");
    write_cfg(cfg(0, 0, 1));
    d = done_cnt;
    col_at = 2;
    col_req = col_done + 1;
    load_frame(12, 41);
    wait_done(d, "R7 thr0");
    chk(exc_cnt == e + 2 && got_ok == 1'b0, "R7 limit 0 drops on first", exc_cnt - e, 2);
  endtask

  task automatic t_fd;
    int e = exc_cnt;
    write_cfg(cfg(0, 0, 1));
    full_duplex = 1'b1;
    col_at = 5;
    col_req = col_done + 1;
    send_one(40, 43, 40, "R8 full duplex");
    chk(exc_cnt == e, "R8 collision ignored", exc_cnt - e, 0);
    full_duplex = 1'b0;
  endtask

  task automatic t_drain;
    int d = done_cnt;
    int seen = 0;
    write_cfg(cfg(15, 0, 1));
    load_frame(50, 47);
    load_frame(30, 53);
    while (!line_valid) @(negedge clk);
    write_cfg(cfg(15, 0, 0));
    wait_done(d, "R9");
    chk(got_ok == 1'b1 && got_len == 50, "R9 frame in progress completes", got_len, 50);
    repeat (150) begin
      @(negedge clk);
      if (line_valid) seen++;
    end
    chk(seen == 0, "R9 next frame held", seen, 0);
    write_cfg(cfg(15, 0, 1));
    wait_done(d + 1, "R9 resume");
    chk(got_len == 30, "R9 queued frame after re-enable", got_len, 30);
    check_bytes(53, 30, 30, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_csr();
    t_hold();
    t_basic();
    t_pad();
    t_retry();
    t_excess();
    t_fd();
    t_drain();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYC, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule